// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit I/O virtual address into a physical address when the translation cache has missed. It splits the address into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. It then walks a two-level table held in memory.

The walk starts with one read of the directory entry, taken from the directory base plus four times the directory index. If that entry is valid, a second read fetches the leaf entry, taken from the table address in the directory entry plus four times the table index. The leaf entry is then checked for validity and for permission against the direction of the access.

A successful walk produces the physical address and, in the same cycle, a fill for the translation cache. A failed walk produces one of two signals:
- a page fault, carrying the faulting address and a write flag;
- a bus error, raised when a table read comes back with an error.

The memory port allows only one read in flight at a time. The walker takes a new request only while it is idle.

Top module: `iova_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid`, `done_valid`, `fill_valid`, `page_fault` and `bus_error` are 0.
- R2: The first read address is `dir_base + 4*vaddr[31:22]`. The second read address is `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: A directory entry whose bit 0 (valid) is 0 ends the walk with `page_fault` after exactly one memory read.
- R4: A leaf entry whose bit 0 (valid) is 0 ends the walk with `page_fault` after two memory reads.
- R5: A write to a leaf with bit 2 (writable) clear, or a read from a leaf with bit 1 (readable) clear, is a page fault. Leaf bits 11:3 have no effect on the result.
- R6: On success, `done_valid` pulses for one cycle with `done_paddr = {leaf[31:12], vaddr[11:0]}`.
- R7: `fill_valid` is high in exactly the cycle `done_valid` is high. During that cycle it carries `fill_vpn = vaddr[31:12]`, `fill_ppn = leaf[31:12]` and `fill_flags = leaf[11:0]`. A walk that ends in a fault produces no fill.
- R8: A response with `mem_rsp_err` high, at either level, ends the walk with a one-cycle `bus_error` pulse and no `page_fault`.
- R9: On a page fault or a bus error, the walker latches `fault_vaddr` and `fault_write`. Both hold their values through later successful walks until the next fault.
- R10: A request is taken only while `req_ready` is 1. A `req_valid` raised during a walk starts no memory read and produces no result.
- R11: `mem_req_valid` is a one-cycle pulse, and no new read is issued while a response is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| dir_base | input | 32 | Byte address of the directory table |
| mem_req_valid | output | 1 | Table read request pulse |
| mem_req_addr | output | 32 | Table read byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response entry |
| mem_rsp_err | input | 1 | Read response error |
| done_valid | output | 1 | Successful translation pulse |
| done_paddr | output | 32 | Translated physical address |
| fill_valid | output | 1 | Translation cache fill pulse |
| fill_vpn | output | 20 | Virtual page number for the fill |
| fill_ppn | output | 20 | Physical page number for the fill |
| fill_flags | output | 12 | Leaf entry low bits for the fill |
| page_fault | output | 1 | Translation fault pulse |
| bus_error | output | 1 | Table read error pulse |
| fault_vaddr | output | 32 | Latched faulting virtual address |
| fault_write | output | 1 | Latched direction of the faulting access |

## Verification
On a successful walk, the result and the cache fill leave the block in the same cycle. The bench therefore samples both at the one negative edge where `done_valid` first rises. It requires the fill's page numbers and flags to agree with the physical address returned in that same cycle. It repeats this for a read mapping, a write mapping and an address at the top directory and offset corners. Every faulting walk is checked to show that no fill appears in the cycle of the fault. A second overlap is provoked by raising `req_valid` while a slow-memory walk is in flight: `req_ready` must stay low, and only the first walk's two reads and its single result may appear.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
   typedef enum logic [2:0] {
      WK_IDLE  = 3'd0,
      WK_DIR   = 3'd1,
      WK_LEAF  = 3'd2,
      WK_DONE  = 3'd3,
      WK_FAULT = 3'd4
   } walk_state_e;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_PAGE = 2'd1,
      FK_BUS  = 2'd2
   } fault_kind_e;

   localparam int unsigned ENT_VALID_BIT = 0;
   localparam int unsigned ENT_RD_BIT    = 1;
   localparam int unsigned ENT_WR_BIT    = 2;
endpackage

// File: rtl/iova_addr_gen.sv
module iova_addr_gen #(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFF_W    = 12,
   parameter int unsigned ENTRY_SH = 2
) (
   input  logic [VA_W-1:0]       vaddr,
   input  logic [VA_W-1:0]       base,
   input  logic [VA_W-OFF_W-1:0] table_pfn,
   output logic [VA_W-1:0]       dir_addr,
   output logic [VA_W-1:0]       leaf_addr
);
   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] leaf_idx;

   assign dir_idx  = vaddr[VA_W-1 -: IDX_W];
   assign leaf_idx = vaddr[OFF_W +: IDX_W];

   assign dir_addr  = base + (VA_W'(dir_idx) << ENTRY_SH);
   assign leaf_addr = {table_pfn, {OFF_W{1'b0}}} + (VA_W'(leaf_idx) << ENTRY_SH);
endmodule

// File: rtl/iova_entry_eval.sv
module iova_entry_eval #(
   parameter bit CHECK_PERM = 1'b1
) (
   input  logic [2:0] ent_low,
   input  logic       is_write,
   output logic       present,
   output logic       allowed
);
   import iova_walk_pkg::*;

   assign present = ent_low[ENT_VALID_BIT];

   generate
      if (CHECK_PERM) begin : g_perm
         assign allowed = is_write ? ent_low[ENT_WR_BIT] : ent_low[ENT_RD_BIT];
      end else begin : g_noperm
         logic unused_perm;
         assign unused_perm = ^{ent_low[ENT_WR_BIT], ent_low[ENT_RD_BIT], is_write};
         assign allowed = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/iova_walk_fsm.sv
module iova_walk_fsm #(
   parameter int unsigned VA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [VA_W-1:0]             dir_addr,
   input  logic [VA_W-1:0]             leaf_addr,
   input  logic                        rsp_valid,
   input  logic                        rsp_err,
   input  logic                        present,
   input  logic                        allowed,
   output logic                        ready,
   output logic                        accept,
   output logic                        leaf_take,
   output logic                        fault_take,
   output logic                        mem_req_valid,
   output logic [VA_W-1:0]             mem_req_addr,
   output iova_walk_pkg::walk_state_e  state,
   output iova_walk_pkg::fault_kind_e  kind
);
   import iova_walk_pkg::*;

   walk_state_e state_d;
   fault_kind_e kind_d;
   logic        issue_d;
   logic [VA_W-1:0] addr_d;

   always_comb begin
      state_d    = state;
      kind_d     = kind;
      issue_d    = 1'b0;
      addr_d     = mem_req_addr;
      leaf_take  = 1'b0;
      fault_take = 1'b0;
      case (state)
         WK_IDLE: begin
            if (req_valid) begin
               state_d = WK_DIR;
               issue_d = 1'b1;
               addr_d  = dir_addr;
               kind_d  = FK_NONE;
            end
         end
         WK_DIR: begin
            if (rsp_valid) begin
               if (rsp_err) begin
                  state_d = WK_FAULT; kind_d = FK_BUS; fault_take = 1'b1;
               end else if (!present) begin
                  state_d = WK_FAULT; kind_d = FK_PAGE; fault_take = 1'b1;
               end else begin
                  state_d = WK_LEAF; issue_d = 1'b1; addr_d = leaf_addr;
               end
            end
         end
         WK_LEAF: begin
            if (rsp_valid) begin
               if (rsp_err) begin
                  state_d = WK_FAULT; kind_d = FK_BUS; fault_take = 1'b1;
               end else if (!present || !allowed) begin
                  state_d = WK_FAULT; kind_d = FK_PAGE; fault_take = 1'b1;
               end else begin
                  state_d = WK_DONE; leaf_take = 1'b1;
               end
            end
         end
         WK_DONE:  state_d = WK_IDLE;
         WK_FAULT: state_d = WK_IDLE;
         default:  state_d = WK_IDLE;
      endcase
   end

   assign ready  = (state == WK_IDLE);
   assign accept = ready && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= WK_IDLE;
         kind          <= FK_NONE;
         mem_req_valid <= 1'b0;
         mem_req_addr  <= '0;
      end else begin
         state         <= state_d;
         kind          <= kind_d;
         mem_req_valid <= issue_d;
         mem_req_addr  <= addr_d;
      end
   end
endmodule

// File: rtl/iova_walker.sv
module iova_walker #(
   parameter int unsigned VA_W        = 32,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter bit          CHECK_PERM  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic                   req_write,
   input  logic [VA_W-1:0]        dir_base,
   output logic                   mem_req_valid,
   output logic [VA_W-1:0]        mem_req_addr,
   input  logic                   mem_rsp_valid,
   input  logic [VA_W-1:0]        mem_rsp_data,
   input  logic                   mem_rsp_err,
   output logic                   done_valid,
   output logic [VA_W-1:0]        done_paddr,
   output logic                   fill_valid,
   output logic [VA_W-OFF_W-1:0]  fill_vpn,
   output logic [VA_W-OFF_W-1:0]  fill_ppn,
   output logic [OFF_W-1:0]       fill_flags,
   output logic                   page_fault,
   output logic                   bus_error,
   output logic [VA_W-1:0]        fault_vaddr,
   output logic                   fault_write
);
   import iova_walk_pkg::*;

   localparam int unsigned PFN_W    = VA_W - OFF_W;
   localparam int unsigned ENTRY_SH = $clog2(ENTRY_BYTES);

   generate
      if (2 * IDX_W + OFF_W != VA_W) begin : g_bad_split
         $error("address split does not cover VA_W");
      end
      if (ENTRY_BYTES * 8 != VA_W) begin : g_bad_entry
         $error("entry width must equal VA_W");
      end
      if ((1 << (IDX_W + ENTRY_SH)) != (1 << OFF_W)) begin : g_bad_table
         $error("a table must fill exactly one page");
      end
   endgenerate

   walk_state_e state;
   fault_kind_e kind;
   logic        accept, leaf_take, fault_take;
   logic        present, allowed;
   logic [VA_W-1:0] dir_addr, leaf_addr, vaddr_sel;
   logic [VA_W-1:0] vaddr_q;
   logic            write_q;
   logic [VA_W-1:0] leaf_q;
   logic [VA_W-1:0] flt_vaddr_q;
   logic            flt_write_q;

   assign vaddr_sel = (state == WK_IDLE) ? req_vaddr : vaddr_q;

   iova_addr_gen #(
      .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENTRY_SH(ENTRY_SH)
   ) u_addr (
      .vaddr     (vaddr_sel),
      .base      (dir_base),
      .table_pfn (mem_rsp_data[VA_W-1:OFF_W]),
      .dir_addr  (dir_addr),
      .leaf_addr (leaf_addr)
   );

   iova_entry_eval #(.CHECK_PERM(CHECK_PERM)) u_eval (
      .ent_low  (mem_rsp_data[2:0]),
      .is_write (write_q),
      .present  (present),
      .allowed  (allowed)
   );

   iova_walk_fsm #(.VA_W(VA_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .dir_addr      (dir_addr),
      .leaf_addr     (leaf_addr),
      .rsp_valid     (mem_rsp_valid),
      .rsp_err       (mem_rsp_err),
      .present       (present),
      .allowed       (allowed),
      .ready         (req_ready),
      .accept        (accept),
      .leaf_take     (leaf_take),
      .fault_take    (fault_take),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .state         (state),
      .kind          (kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vaddr_q     <= '0;
         write_q     <= 1'b0;
         leaf_q      <= '0;
         flt_vaddr_q <= '0;
         flt_write_q <= 1'b0;
      end else begin
         if (accept) begin
            vaddr_q <= req_vaddr;
            write_q <= req_write;
         end
         if (leaf_take) leaf_q <= mem_rsp_data;
         if (fault_take) begin
            flt_vaddr_q <= vaddr_q;
            flt_write_q <= write_q;
         end
      end
   end

   assign done_valid  = (state == WK_DONE);
   assign done_paddr  = {leaf_q[VA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
   assign fill_valid  = (state == WK_DONE);
   assign fill_vpn    = vaddr_q[VA_W-1:OFF_W];
   assign fill_ppn    = leaf_q[VA_W-1:OFF_W];
   assign fill_flags  = leaf_q[OFF_W-1:0];
   assign page_fault  = (state == WK_FAULT) && (kind == FK_PAGE);
   assign bus_error   = (state == WK_FAULT) && (kind == FK_BUS);
   assign fault_vaddr = flt_vaddr_q;
   assign fault_write = flt_write_q;

   logic unused_pfn;
   assign unused_pfn = ^{PFN_W[0]};
endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk #(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned OFF_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic                  mem_req_valid,
   input logic                  mem_rsp_valid,
   input logic                  done_valid,
   input logic [VA_W-1:0]       done_paddr,
   input logic                  fill_valid,
   input logic [VA_W-OFF_W-1:0] fill_ppn,
   input logic                  page_fault,
   input logic                  bus_error
);
   logic outstanding_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outstanding_q <= 1'b0;
      else if (mem_req_valid) outstanding_q <= 1'b1;
      else if (mem_rsp_valid) outstanding_q <= 1'b0;
   end

   // R11
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R11
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !outstanding_q);

   // R7
   fill_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (done_valid && fill_ppn == done_paddr[VA_W-1:OFF_W]));

   // R8
   bus_not_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_error |-> (!page_fault && !done_valid));

   // R10
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
endmodule

bind iova_walker iova_walker_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_rsp_valid (mem_rsp_valid),
   .done_valid    (done_valid),
   .done_paddr    (done_paddr),
   .fill_valid    (fill_valid),
   .fill_ppn      (fill_ppn),
   .page_fault    (page_fault),
   .bus_error     (bus_error)
);

// File: tb/iova_walker_tb_top.sv
`timescale 1ns/1ps
module iova_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [31:0] dir_base = 32'h0010_0000;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        done_valid;
   logic [31:0] done_paddr;
   logic        fill_valid;
   logic [19:0] fill_vpn;
   logic [19:0] fill_ppn;
   logic [11:0] fill_flags;
   logic        page_fault;
   logic        bus_error;
   logic [31:0] fault_vaddr;
   logic        fault_write;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   logic [31:0] mem [int unsigned];
   int          lat = 1;
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   int          req_count = 0;
   int          overlap = 0;
   logic [31:0] req_addrs [0:3];
   bit          pend = 0;
   int          wait_n = 0;
   logic [31:0] pend_addr = '0;

   always #2 clk = ~clk;

   iova_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .dir_base(dir_base),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .done_valid(done_valid), .done_paddr(done_paddr), .fill_valid(fill_valid),
      .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_flags(fill_flags),
      .page_fault(page_fault), .bus_error(bus_error),
      .fault_vaddr(fault_vaddr), .fault_write(fault_write)
   );

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (pend) begin
         if (wait_n == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            mem_rsp_err   = (pend_addr == err_addr);
            pend = 0;
         end else begin
            wait_n = wait_n - 1;
         end
      end
      if (rst_n && mem_req_valid) begin
         if (pend) overlap = overlap + 1;
         pend = 1;
         pend_addr = mem_req_addr;
         wait_n = lat;
         if (req_count < 4) req_addrs[req_count] = mem_req_addr;
         req_count = req_count + 1;
      end
   end

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_slot(input logic [31:0] va);
      return dir_base + {20'h0, va[31:22], 2'b00};
   endfunction

   function automatic logic [31:0] leaf_slot(input logic [31:0] tbl, input logic [31:0] va);
      return {tbl[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
   endfunction

   // kind: 0 success, 1 page fault, 2 bus error
   task automatic do_walk(input logic [31:0] va, input logic wr, input int kind,
                          input logic [31:0] exp_pa, input logic [11:0] exp_flags,
                          input int exp_reqs, input string tag);
      int n;
      @(negedge clk);
      req_count = 0;
      req_vaddr = va; req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!(done_valid || page_fault || bus_error) && n < 300) begin
         @(negedge clk); n++;
      end
      if (kind == 0) begin
         chk(done_valid && !page_fault && !bus_error, {tag, " R6 done"}, {page_fault, bus_error, done_valid}, 3'b001);
         chk(done_paddr == exp_pa, {tag, " R6 paddr"}, done_paddr, exp_pa);
         chk(fill_valid == 1'b1, {tag, " R7 fill same cycle"}, fill_valid, 1);
         chk(fill_vpn == va[31:12], {tag, " R7 vpn"}, fill_vpn, va[31:12]);
         chk(fill_ppn == exp_pa[31:12], {tag, " R7 ppn"}, fill_ppn, exp_pa[31:12]);
         chk(fill_flags == exp_flags, {tag, " R7 flags"}, fill_flags, exp_flags);
      end else begin
         chk(!done_valid && !fill_valid, {tag, " R7 no fill on fault"}, {done_valid, fill_valid}, 0);
         chk(page_fault == (kind == 1) && bus_error == (kind == 2), {tag, " R8 fault kind"},
             {page_fault, bus_error}, (kind == 1) ? 2'b10 : 2'b01);
         chk(fault_vaddr == va && fault_write == wr, {tag, " R9 latched fault"},
             {fault_write, fault_vaddr}, {wr, va});
      end
      chk(req_count == exp_reqs, {tag, " R11 read count"}, req_count, exp_reqs);
      @(negedge clk);
      chk(!done_valid && !page_fault && !bus_error && !fill_valid && req_ready,
          {tag, " R6 one-cycle result"}, {done_valid, page_fault, bus_error, fill_valid, req_ready}, 5'b00001);
   endtask

   task automatic t_reset();
      chk(req_ready && !mem_req_valid && !done_valid && !fill_valid && !page_fault && !bus_error,
          "R1 reset state", {req_ready, mem_req_valid, done_valid, fill_valid, page_fault, bus_error}, 6'b100000);
   endtask

   task automatic t_read_map();
      logic [31:0] va = 32'h1234_5678;
      mem[dir_slot(va)] = 32'h0020_0001;
      mem[leaf_slot(32'h0020_0000, va)] = 32'hABCD_E000 | 32'h1F8 | 32'h3;
      do_walk(va, 1'b0, 0, 32'hABCD_E678, 12'h1FB, 2, "read map R5");
      chk(req_addrs[0] == dir_slot(va), "R2 directory address", req_addrs[0], dir_slot(va));
      chk(req_addrs[1] == 32'h0020_0D14, "R2 leaf address", req_addrs[1], 32'h0020_0D14);
   endtask

   task automatic t_write_denied();
      do_walk(32'h1234_5ABC, 1'b1, 1, '0, '0, 2, "write to read-only R5");
   endtask

   task automatic t_write_ok();
      logic [31:0] va = 32'h1234_6010;
      mem[leaf_slot(32'h0020_0000, va)] = 32'h5555_5000 | 32'h5;
      do_walk(va, 1'b1, 0, 32'h5555_5010, 12'h005, 2, "writable page R5");
   endtask

   task automatic t_read_denied();
      logic [31:0] va = 32'h1234_7000;
      mem[leaf_slot(32'h0020_0000, va)] = 32'h7777_7000 | 32'h5;
      do_walk(va, 1'b0, 1, '0, '0, 2, "read from write-only R5");
   endtask

   task automatic t_dir_invalid();
      logic [31:0] va = 32'h4000_1234;
      mem[dir_slot(va)] = 32'h0030_0000;
      do_walk(va, 1'b1, 1, '0, '0, 1, "invalid directory R3");
   endtask

   task automatic t_leaf_invalid();
      logic [31:0] va = 32'h1230_0000;
      mem[leaf_slot(32'h0020_0000, va)] = 32'h8888_8006;
      do_walk(va, 1'b0, 1, '0, '0, 2, "invalid leaf R4");
   endtask

   task automatic t_corner();
      logic [31:0] va = 32'hFFFF_FFFF;
      mem[dir_slot(va)] = 32'h00F0_0FFF;
      mem[leaf_slot(32'h00F0_0000, va)] = 32'hFEDC_B003;
      do_walk(va, 1'b0, 0, 32'hFEDC_BFFF, 12'h003, 2, "top corner R2");
      chk(req_addrs[1] == 32'h00F0_0FFC, "R2 last leaf slot", req_addrs[1], 32'h00F0_0FFC);
   endtask

   task automatic t_bus_errors();
      logic [31:0] va = 32'h1234_5000;
      err_addr = dir_slot(32'h8000_0000);
      do_walk(32'h8000_0000, 1'b1, 2, '0, '0, 1, "directory read error R8");
      err_addr = leaf_slot(32'h0020_0000, va);
      do_walk(va, 1'b0, 2, '0, '0, 2, "leaf read error R8");
      err_addr = 32'hFFFF_FFFF;
   endtask

   task automatic t_fault_hold();
      do_walk(32'h1234_5678, 1'b0, 0, 32'hABCD_E678, 12'h1FB, 2, "walk after fault");
      chk(fault_vaddr == 32'h1234_5000 && fault_write == 1'b0, "R9 fault info held",
          {fault_write, fault_vaddr}, {1'b0, 32'h1234_5000});
   endtask

   task automatic t_busy_ignore();
      int n;
      lat = 6;
      @(negedge clk);
      req_count = 0;
      req_vaddr = 32'h1234_5678; req_write = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_vaddr = 32'h1234_6010; req_write = 1'b1; req_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!req_ready, "R10 busy not ready", req_ready, 0);
      end
      req_valid = 1'b0;
      n = 0;
      while (!(done_valid || page_fault || bus_error) && n < 300) begin
         @(negedge clk); n++;
      end
      chk(done_valid && done_paddr == 32'hABCD_E678, "R10 first walk result", done_paddr, 32'hABCD_E678);
      chk(fill_valid && fill_vpn == 20'h12345, "R7 fill under slow memory", fill_vpn, 20'h12345);
      for (int i = 0; i < 10; i++) @(negedge clk);
      chk(req_count == 2 && !done_valid && req_ready, "R10 ignored request left no trace",
          req_count, 2);
      lat = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_map();
      t_write_denied();
      t_write_ok();
      t_read_denied();
      t_dir_invalid();
      t_leaf_invalid();
      t_corner();
      t_bus_errors();
      t_fault_hold();
      lat = 0;
      t_write_ok();
      lat = 1;
      t_busy_ignore();
      chk(overlap == 0, "R11 no overlapping reads", overlap, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule